// File: doc/BRIEF.md
# Master Clock Ratio Auto-Detector

This block works out how fast the master clock runs compared with the audio sample rate. It runs on the master clock, which is its only clock. It counts master clock cycles from one rising edge of an already-synchronized word-select (left/right) clock to the next. Each count is compared against five allowed ratios. Which five depends on the selected interpolation mode.

When two periods in a row land on the same allowed ratio, the block raises its lock flag. It also publishes a ratio code and a divide value for the interpolator and modulator clock dividers, so no software programming is needed. The divide value is the measured ratio divided by the modulator oversampling rate of the mode. The clock dividers themselves are outside this block.

A count that fits no allowed ratio drops the lock but keeps the last divide setting. A change of the mode input starts detection over.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is applied, and afterwards until a lock occurs, `locked` is 0, `ratio_code` is 0 and `div_val` is 0.
- R2: Mode encoding is 0 for 8x, 1 for 4x, 2 for 2x and 3 for reserved. In 8x mode the modulator rate is 128 FS. The allowed ratios 256, 384, 512, 768 and 1024 give `ratio_code` 0, 1, 2, 3, 4 and `div_val` 2, 3, 4, 6, 8.
- R3: In 4x mode the modulator rate is 64 FS. The allowed ratios 128, 192, 256, 384 and 512 give codes 0 to 4 and divide values 2, 3, 4, 6, 8.
- R4: In 2x mode the modulator rate is 32 FS. The allowed ratios 64, 96, 128, 192 and 256 give codes 0 to 4 and divide values 2, 3, 4, 6, 8.
- R5: A period is the number of master clock cycles between two consecutive cycles in which `lrclk_sync` is sampled high after being low. Outputs change on the clock edge that samples the closing rising edge.
- R6: A period counts as an allowed ratio when it lies within plus or minus 2 cycles of it, both limits included.
- R7: A period outside every window clears `locked` and leaves `ratio_code` and `div_val` unchanged.
- R8: `locked` sets only when a measured period matches the same allowed ratio as the period just before it. The first rising edge after reset or a mode change only starts the count.
- R9: A change of `interp_mode` clears `locked` on the next clock edge and discards any pending match.
- R10: In the reserved mode no period matches, so `locked` stays 0 and the divide setting is held.
- R11: The period counter saturates at its maximum value instead of wrapping, so an overlong period never matches.
- R12: While locked, a period matching a different allowed ratio clears `locked`. The new ratio locks if the following period agrees with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all state is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk_sync | input | 1 | Word-select clock, already synchronized to `clk` |
| interp_mode | input | 2 | Interpolation mode: 0 = 8x, 1 = 4x, 2 = 2x, 3 = reserved |
| locked | output | 1 | Set once the ratio has been confirmed on two consecutive periods |
| ratio_code | output | 3 | Index of the detected ratio within the mode's set |
| div_val | output | 4 | Divide setting = detected ratio / modulator rate |

## Verification
A miscounted period shows up at the rising edge of the word-select clock that closes it. There, `locked` or `div_val` takes a value different from the one the driven period implies. A stale candidate or a lost mode register shows up one period later, as a lock that comes one edge too early or too late. A counter that wraps instead of saturating shows up when an overlong period makes the block lock on a false ratio. The bench therefore samples the outputs after every period that matters, not only at the end of each scenario.

// File: rtl/mclk_det_pkg.sv
package mclk_det_pkg;

    localparam int NUM_RATIOS = 5;
    localparam int CODE_W     = $clog2(NUM_RATIOS);
    localparam int DIV_W      = 4;

    typedef enum logic [1:0] {
        MODE_INT8 = 2'd0,
        MODE_INT4 = 2'd1,
        MODE_INT2 = 2'd2,
        MODE_RSVD = 2'd3
    } interp_mode_e;

    // Multiple of the modulator rate for each ratio index; also the divide value
    function automatic int unsigned ratio_mult(input int unsigned idx);
        case (idx)
            0:       return 2;
            1:       return 3;
            2:       return 4;
            3:       return 6;
            4:       return 8;
            default: return 0;
        endcase
    endfunction

    // Modulator oversampling rate per mode, in units of FS; 0 means no valid set
    function automatic int unsigned mod_rate(input logic [1:0] mode);
        case (mode)
            MODE_INT8: return 128;
            MODE_INT4: return 64;
            MODE_INT2: return 32;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/lrclk_period_meter.sv
module lrclk_period_meter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lrclk_sync,
    input  logic [1:0]       interp_mode,
    output logic             period_valid,
    output logic [CNT_W-1:0] period,
    output logic             mode_chg
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             prev;
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       mode;
    } meter_t;

    meter_t st_d, st_q;
    logic   rise;

    always_comb begin
        st_d     = st_q;
        rise     = lrclk_sync & ~st_q.prev;
        mode_chg = (interp_mode != st_q.mode);
        st_d.prev = lrclk_sync;
        st_d.mode = interp_mode;
        if (mode_chg) begin
            st_d.armed = 1'b0;
            st_d.cnt   = CNT_W'(1);
        end else if (rise) begin
            st_d.armed = 1'b1;
            st_d.cnt   = CNT_W'(1);
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        period_valid = rise & st_q.armed & ~mode_chg;
        period       = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev  <= 1'b0;
            st_q.armed <= 1'b0;
            st_q.cnt   <= CNT_W'(1);
            st_q.mode  <= 2'd0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ratio_matcher.sv
module ratio_matcher
    import mclk_det_pkg::*;
#(
    parameter int          CNT_W = 12,
    parameter int unsigned TOL   = 2
) (
    input  logic [CNT_W-1:0]  period,
    input  logic [1:0]        interp_mode,
    output logic              hit,
    output logic [CODE_W-1:0] idx
);
    logic [NUM_RATIOS-1:0] match_vec;
    logic [31:0]           p32;

    assign p32 = 32'(period);

    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_window
        logic [31:0] tgt;
        assign tgt = mod_rate(interp_mode) * ratio_mult(g);
        assign match_vec[g] = (tgt != 32'd0) && (p32 + TOL >= tgt) && (p32 <= tgt + TOL);
    end

    always_comb begin
        hit = |match_vec;
        idx = '0;
        for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
            if (match_vec[i]) idx = CODE_W'(i);
        end
    end

endmodule

// File: rtl/lock_tracker.sv
module lock_tracker
    import mclk_det_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_chg,
    input  logic              period_valid,
    input  logic              hit,
    input  logic [CODE_W-1:0] idx,
    output logic              locked,
    output logic [CODE_W-1:0] code,
    output logic [DIV_W-1:0]  div_val
);
    typedef struct packed {
        logic              locked;
        logic              cand_valid;
        logic [CODE_W-1:0] cand;
        logic [CODE_W-1:0] code;
        logic [DIV_W-1:0]  div;
    } track_t;

    track_t tr_d, tr_q;

    always_comb begin
        tr_d = tr_q;
        if (mode_chg) begin
            tr_d.locked     = 1'b0;
            tr_d.cand_valid = 1'b0;
        end else if (period_valid) begin
            if (!hit) begin
                tr_d.locked     = 1'b0;
                tr_d.cand_valid = 1'b0;
            end else if (tr_q.cand_valid && tr_q.cand == idx) begin
                tr_d.locked = 1'b1;
                tr_d.code   = idx;
                tr_d.div    = DIV_W'(ratio_mult(32'(idx)));
            end else begin
                tr_d.locked     = 1'b0;
                tr_d.cand_valid = 1'b1;
                tr_d.cand       = idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tr_q <= '0;
        end else begin
            tr_q <= tr_d;
        end
    end

    assign locked  = tr_q.locked;
    assign code    = tr_q.code;
    assign div_val = tr_q.div;

endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
    import mclk_det_pkg::*;
#(
    parameter int          CNT_W = 12,
    parameter int unsigned TOL   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lrclk_sync,
    input  logic [1:0]        interp_mode,
    output logic              locked,
    output logic [CODE_W-1:0] ratio_code,
    output logic [DIV_W-1:0]  div_val
);
    logic              period_valid;
    logic [CNT_W-1:0]  period;
    logic              mode_chg;
    logic              hit;
    logic [CODE_W-1:0] idx;

    lrclk_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .lrclk_sync   (lrclk_sync),
        .interp_mode  (interp_mode),
        .period_valid (period_valid),
        .period       (period),
        .mode_chg     (mode_chg)
    );

    ratio_matcher #(.CNT_W(CNT_W), .TOL(TOL)) u_match (
        .period      (period),
        .interp_mode (interp_mode),
        .hit         (hit),
        .idx         (idx)
    );

    lock_tracker u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_chg     (mode_chg),
        .period_valid (period_valid),
        .hit          (hit),
        .idx          (idx),
        .locked       (locked),
        .code         (ratio_code),
        .div_val      (div_val)
    );

endmodule

// File: rtl/mclk_ratio_detect_chk.sv
module mclk_ratio_detect_chk
    import mclk_det_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lrclk_sync,
    input logic [1:0]        interp_mode,
    input logic              locked,
    input logic [CODE_W-1:0] ratio_code,
    input logic [DIV_W-1:0]  div_val
);
    AST_CODE_DIV_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (div_val == DIV_W'(ratio_mult(32'(ratio_code))))); // R2

    AST_LOCK_ON_LR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(lrclk_sync)); // R5

    AST_DIV_ONLY_WITH_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_val) |-> locked); // R7

    AST_MODE_CHG_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(interp_mode) |=> !locked); // R9

    AST_RSVD_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (interp_mode == MODE_RSVD) |=> !locked); // R10

endmodule

bind mclk_ratio_detect mclk_ratio_detect_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lrclk_sync  (lrclk_sync),
    .interp_mode (interp_mode),
    .locked      (locked),
    .ratio_code  (ratio_code),
    .div_val     (div_val)
);

// File: tb/tb_mclk_ratio_detect.sv
module tb_mclk_ratio_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lrclk = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       locked;
    logic [2:0] ratio_code;
    logic [3:0] div_val;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    mclk_ratio_detect dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lrclk_sync  (lrclk),
        .interp_mode (mode),
        .locked      (locked),
        .ratio_code  (ratio_code),
        .div_val     (div_val)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input int l, input int c, input int d);
        check({req, " locked"}, int'(locked), l);
        check({req, " code"}, int'(ratio_code), c);
        check({req, " div"}, int'(div_val), d);
    endtask

    // One word-select period of p cycles, starting with a rising edge
    task automatic one_period(input int p);
        lrclk = 1'b1;
        repeat (p / 2) @(negedge clk);
        lrclk = 1'b0;
        repeat (p - p / 2) @(negedge clk);
    endtask

    task automatic periods(input int p, input int n);
        for (int i = 0; i < n; i++) one_period(p);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode = m;
        @(negedge clk);
        check("R9 unlock on mode change", int'(locked), 0);
    endtask

    task automatic t_reset;
        check_out("R1 reset", 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 after release", 0, 0, 0);
    endtask

    task automatic t_int8_lock;
        one_period(1024);
        check("R8 first edge arms", int'(locked), 0);
        one_period(1024);
        check("R8 one match only", int'(locked), 0);
        one_period(1024);
        check_out("R2 R5 lock 1024", 1, 4, 8);
    endtask

    task automatic t_switch_ratio;
        one_period(384);
        check_out("R12 old period still locked", 1, 4, 8);
        one_period(384);
        check_out("R12 new ratio drops lock", 0, 4, 8);
        one_period(384);
        check_out("R2 lock 384", 1, 1, 3);
    endtask

    task automatic t_int4;
        set_mode(2'd1);
        one_period(192);
        check("R9 first edge after change arms", int'(locked), 0);
        one_period(192);
        check("R9 R8 candidate", int'(locked), 0);
        one_period(192);
        check_out("R3 lock 192", 1, 1, 3);
        periods(512, 3);
        check_out("R3 lock 512", 1, 4, 8);
    endtask

    task automatic t_int2;
        set_mode(2'd2);
        periods(64, 3);
        check_out("R4 lock 64", 1, 0, 2);
        periods(256, 3);
        check_out("R4 lock 256", 1, 4, 8);
        periods(96, 3);
        check_out("R4 lock 96", 1, 1, 3);
    endtask

    task automatic t_tolerance;
        set_mode(2'd0);
        periods(514, 3);
        check_out("R6 upper limit", 1, 2, 4);
        periods(510, 2);
        check_out("R6 lower limit", 1, 2, 4);
        one_period(515);
        check("R7 previous still locked", int'(locked), 1);
        one_period(515);
        check_out("R7 out of window", 0, 2, 4);
    endtask

    task automatic t_two_consecutive;
        one_period(768);
        check_out("R8 bad period measured", 0, 2, 4);
        one_period(768);
        check_out("R8 single match no lock", 0, 2, 4);
        one_period(768);
        check_out("R8 second match locks", 1, 3, 6);
    endtask

    task automatic t_reserved;
        set_mode(2'd3);
        periods(512, 4);
        check_out("R10 reserved mode", 0, 3, 6);
    endtask

    task automatic t_saturate;
        set_mode(2'd0);
        periods(5120, 4);
        check_out("R11 saturated count", 0, 3, 6);
    endtask

    initial begin
        t_reset();
        t_int8_lock();
        t_switch_ratio();
        t_int4();
        t_int2();
        t_tolerance();
        t_two_consecutive();
        t_reserved();
        t_saturate();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule